// File: doc/BRIEF.md
# Split-Pointer Frame Ring Tracker

This block keeps the bookkeeping for a circular buffer whose unit is a 32-byte frame and whose length is a power of two. It stores no data. It holds four frame indices. On the producer side there is a reserved ("allocated") index and a committed index. On the consumer side there is an inspected ("peeked") index and a released ("discarded") index. Two indices per side let a producer claim space before the data lands, and let a consumer look at data before giving its slots back.

A controller drives one operation per cycle on a small op code. The operations are:
- a clamped bulk write or bulk read of any number of frames;
- reservation or inspection of one 16-frame multiframe;
- commit or release of one multiframe;
- a flush that pulls the consumer back to the last multiframe boundary at or below the committed index;
- a re-initialisation that loads a new base offset and length.

For each grant the block returns the buffer offset (base plus index) and the frame count. It also shows the four occupancy counts continuously.

Top module: `frame_ring_ptrs`

## Requirements
- R1: While reset is asserted and after its release, the allocated, valid and unseen counts are 0, the free count is 2^MAX_LOG2 − 1, and grant_vld and refuse are low. The base offset is 0.
- R2: Op code 1 (init) loads init_base as the base and 2^init_log2 as the length, with init_log2 limited to MAX_LOG2. It sets all four indices to 0. It grants nothing.
- R3: With mask = length − 1, the counts are: allocated = (reserved − released) & mask, valid = (committed − released) & mask, unseen = (committed − inspected) & mask, free = (released − reserved − 1) & mask. One slot therefore always stays empty.
- R4: Op code 2 (bulk write) grants the smallest of three values: req_frames, the free count, and mask − committed + 1. The offset is base + committed. Both producer indices move to (committed + grant) & mask.
- R5: Op code 3 (bulk read) grants the smallest of three values: req_frames, the unseen count, and mask − inspected + 1. The offset is base + inspected. Both consumer indices move to (inspected + grant) & mask.
- R6: Op code 4 (reserve) succeeds only when the free count is at least 16. It then grants 16 frames at base + reserved and advances only the reserved index by 16. Otherwise refuse rises and no index changes.
- R7: Op code 5 (commit) advances the committed index by 16, modulo the length, and grants nothing.
- R8: Op code 6 (peek) succeeds only when the unseen count is at least 16. It then grants 16 frames at base + inspected and advances only the inspected index by 16. Otherwise refuse rises and no index changes.
- R9: Op code 7 (discard) advances the released index by 16, modulo the length, and grants nothing.
- R10: Op code 8 (flush) sets both consumer indices to the committed index with its low 4 bits cleared.
- R11: Grant results appear in the cycle after the op. Ops without a grant drive grant_vld, grant_frames and grant_ofs to 0. A bulk grant of zero frames still raises grant_vld.
- R12: Op code 0 (idle) changes no count and raises neither grant_vld nor refuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation for this cycle |
| req_frames | input | MAX_LOG2+1 | Frames requested by a bulk op |
| init_base | input | BASE_W | Base offset loaded by init |
| init_log2 | input | LOG_W | log2 of the length loaded by init |
| grant_vld | output | 1 | A region was granted last cycle |
| grant_ofs | output | BASE_W | Buffer offset of the granted region |
| grant_frames | output | MAX_LOG2+1 | Frames in the granted region |
| refuse | output | 1 | Reserve or peek was refused last cycle |
| cnt_allocd | output | MAX_LOG2 | Allocated count |
| cnt_valid | output | MAX_LOG2 | Valid count |
| cnt_unseen | output | MAX_LOG2 | Unseen count |
| cnt_free | output | MAX_LOG2 | Free count |

## Verification
The two clamps on a bulk grant, room left before the buffer end and the free (or unseen) count, act in the same cycle. The grant takes whichever is smaller. The sequence sets both up on purpose. In one bulk write the request exceeds both limits and the end-of-buffer room is the smaller one, so the grant is cut at the wrap. The next bulk write starts at offset zero and is limited by the free count alone. A later bulk read is again cut at the end while unseen is larger. Each grant is judged against the minimum computed by hand, and the offset is checked against base + index.

// File: rtl/frame_ring_pkg.sv
package frame_ring_pkg;
  typedef enum logic [3:0] {
    OP_IDLE    = 4'd0,
    OP_INIT    = 4'd1,
    OP_BULK_WR = 4'd2,
    OP_BULK_RD = 4'd3,
    OP_RESERVE = 4'd4,
    OP_COMMIT  = 4'd5,
    OP_PEEK    = 4'd6,
    OP_DISCARD = 4'd7,
    OP_FLUSH   = 4'd8
  } ring_op_e;

  localparam int unsigned MF_FRAMES = 16;
endpackage

// File: rtl/ring_level_calc.sv
module ring_level_calc #(
  parameter int unsigned PW = 7
) (
  input  logic [PW-1:0] mask,
  input  logic [PW-1:0] rsv_ptr,
  input  logic [PW-1:0] cmt_ptr,
  input  logic [PW-1:0] ins_ptr,
  input  logic [PW-1:0] rel_ptr,
  output logic [PW-1:0] allocd,
  output logic [PW-1:0] valid,
  output logic [PW-1:0] unseen,
  output logic [PW-1:0] free
);
  always_comb begin
    allocd = (rsv_ptr - rel_ptr) & mask;
    valid  = (cmt_ptr - rel_ptr) & mask;
    unseen = (cmt_ptr - ins_ptr) & mask;
    free   = (rel_ptr - rsv_ptr - PW'(1)) & mask;
  end
endmodule

// File: rtl/ring_grant_clamp.sv
module ring_grant_clamp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] want,
  input  logic [W-1:0] avail,
  input  logic [W-1:0] to_end,
  output logic [W-1:0] grant
);
  logic [W-1:0] lim;
  always_comb begin
    lim   = (avail < to_end) ? avail : to_end;
    grant = (want < lim) ? want : lim;
  end
endmodule

// File: rtl/frame_ring_ptrs.sv
module frame_ring_ptrs
  import frame_ring_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = 7,
  parameter int unsigned BASE_W   = 9,
  parameter int unsigned LOG_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          op_code,
  input  logic [MAX_LOG2:0]   req_frames,
  input  logic [BASE_W-1:0]   init_base,
  input  logic [LOG_W-1:0]    init_log2,
  output logic                grant_vld,
  output logic [BASE_W-1:0]   grant_ofs,
  output logic [MAX_LOG2:0]   grant_frames,
  output logic                refuse,
  output logic [MAX_LOG2-1:0] cnt_allocd,
  output logic [MAX_LOG2-1:0] cnt_valid,
  output logic [MAX_LOG2-1:0] cnt_unseen,
  output logic [MAX_LOG2-1:0] cnt_free
);
  localparam int unsigned PW = MAX_LOG2;
  localparam int unsigned GW = PW + 1;
  localparam logic [PW-1:0] MF_STEP  = PW'(MF_FRAMES);
  localparam logic [PW-1:0] MF_ALIGN = ~PW'(MF_FRAMES - 1);
  localparam logic [PW-1:0] RST_MASK = PW'((64'd1 << PW) - 64'd1);

  ring_op_e op;
  assign op = ring_op_e'(op_code);

  // state
  logic [BASE_W-1:0] base_q, base_d;
  logic [PW-1:0]     mask_q, mask_d;
  logic [PW-1:0]     rsv_q, rsv_d, cmt_q, cmt_d, ins_q, ins_d, rel_q, rel_d;
  logic              gv_q, gv_d, rf_q, rf_d;
  logic [BASE_W-1:0] go_q, go_d;
  logic [GW-1:0]     gf_q, gf_d;
  logic              state_en;

  // occupancy
  logic [PW-1:0] allocd, valid, unseen, free;
  ring_level_calc #(.PW(PW)) u_level (
    .mask(mask_q), .rsv_ptr(rsv_q), .cmt_ptr(cmt_q), .ins_ptr(ins_q), .rel_ptr(rel_q),
    .allocd(allocd), .valid(valid), .unseen(unseen), .free(free)
  );

  // bulk clamps, one per side
  logic [GW-1:0] wr_end, rd_end, wr_grant, rd_grant;
  assign wr_end = {1'b0, mask_q} - {1'b0, cmt_q} + GW'(1);
  assign rd_end = {1'b0, mask_q} - {1'b0, ins_q} + GW'(1);

  ring_grant_clamp #(.W(GW)) u_wr_clamp (
    .want(req_frames), .avail({1'b0, free}), .to_end(wr_end), .grant(wr_grant)
  );
  ring_grant_clamp #(.W(GW)) u_rd_clamp (
    .want(req_frames), .avail({1'b0, unseen}), .to_end(rd_end), .grant(rd_grant)
  );

  logic mf_room, mf_ready;
  assign mf_room  = {1'b0, free}   >= GW'(MF_FRAMES);
  assign mf_ready = {1'b0, unseen} >= GW'(MF_FRAMES);

  logic [LOG_W-1:0] len_eff;
  assign len_eff = (32'(init_log2) > PW) ? LOG_W'(PW) : init_log2;

  // next state
  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    rsv_d  = rsv_q;
    cmt_d  = cmt_q;
    ins_d  = ins_q;
    rel_d  = rel_q;
    gv_d   = 1'b0;
    rf_d   = 1'b0;
    go_d   = '0;
    gf_d   = '0;
    unique case (op)
      OP_INIT: begin
        base_d = init_base;
        mask_d = PW'((32'd1 << len_eff) - 32'd1);
        rsv_d  = '0;
        cmt_d  = '0;
        ins_d  = '0;
        rel_d  = '0;
      end
      OP_BULK_WR: begin
        gv_d  = 1'b1;
        gf_d  = wr_grant;
        go_d  = base_q + BASE_W'(cmt_q);
        cmt_d = (cmt_q + PW'(wr_grant)) & mask_q;
        rsv_d = (cmt_q + PW'(wr_grant)) & mask_q;
      end
      OP_BULK_RD: begin
        gv_d  = 1'b1;
        gf_d  = rd_grant;
        go_d  = base_q + BASE_W'(ins_q);
        ins_d = (ins_q + PW'(rd_grant)) & mask_q;
        rel_d = (ins_q + PW'(rd_grant)) & mask_q;
      end
      OP_RESERVE: begin
        if (mf_room) begin
          gv_d  = 1'b1;
          gf_d  = GW'(MF_FRAMES);
          go_d  = base_q + BASE_W'(rsv_q);
          rsv_d = (rsv_q + MF_STEP) & mask_q;
        end else begin
          rf_d = 1'b1;
        end
      end
      OP_COMMIT:  cmt_d = (cmt_q + MF_STEP) & mask_q;
      OP_PEEK: begin
        if (mf_ready) begin
          gv_d  = 1'b1;
          gf_d  = GW'(MF_FRAMES);
          go_d  = base_q + BASE_W'(ins_q);
          ins_d = (ins_q + MF_STEP) & mask_q;
        end else begin
          rf_d = 1'b1;
        end
      end
      OP_DISCARD: rel_d = (rel_q + MF_STEP) & mask_q;
      OP_FLUSH: begin
        ins_d = cmt_q & MF_ALIGN;
        rel_d = cmt_q & MF_ALIGN;
      end
      default: ;
    endcase
  end

  assign state_en = (op != OP_IDLE);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= RST_MASK;
      rsv_q  <= '0;
      cmt_q  <= '0;
      ins_q  <= '0;
      rel_q  <= '0;
    end else if (state_en) begin
      base_q <= base_d;
      mask_q <= mask_d;
      rsv_q  <= rsv_d;
      cmt_q  <= cmt_d;
      ins_q  <= ins_d;
      rel_q  <= rel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q <= 1'b0;
      rf_q <= 1'b0;
      go_q <= '0;
      gf_q <= '0;
    end else begin
      gv_q <= gv_d;
      rf_q <= rf_d;
      go_q <= go_d;
      gf_q <= gf_d;
    end
  end

  assign grant_vld    = gv_q;
  assign grant_ofs    = go_q;
  assign grant_frames = gf_q;
  assign refuse       = rf_q;
  assign cnt_allocd   = allocd;
  assign cnt_valid    = valid;
  assign cnt_unseen   = unseen;
  assign cnt_free     = free;
endmodule

// File: rtl/frame_ring_ptrs_chk.sv
module frame_ring_ptrs_chk #(
  parameter int unsigned PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_code,
  input logic [PW:0]   req_frames,
  input logic [PW-1:0] mask_q,
  input logic          grant_vld,
  input logic [PW:0]   grant_frames,
  input logic          refuse,
  input logic [PW-1:0] cnt_allocd,
  input logic [PW-1:0] cnt_valid,
  input logic [PW-1:0] cnt_unseen,
  input logic [PW-1:0] cnt_free
);
  // R3
  slot_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(cnt_allocd + cnt_free) == mask_q);

  // R4
  bulk_wr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == 4'd2 |=> grant_vld && grant_frames <= $past(req_frames)
                        && grant_frames <= {1'b0, $past(cnt_free)});

  // R6
  reserve_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd4 && cnt_free < PW'(16)) |=> refuse && !grant_vld && $stable(cnt_allocd));

  // R8
  peek_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd6 && cnt_unseen < PW'(16)) |=> refuse && !grant_vld && $stable(cnt_unseen));

  // R10
  flush_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == 4'd8 |=> cnt_unseen == cnt_valid && cnt_unseen < PW'(16));

  // R11
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_vld && refuse));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == 4'd0 |=> $stable(cnt_free) && $stable(cnt_unseen) && !grant_vld && !refuse);
endmodule

bind frame_ring_ptrs frame_ring_ptrs_chk #(.PW(MAX_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .req_frames(req_frames), .mask_q(mask_q),
  .grant_vld(grant_vld), .grant_frames(grant_frames), .refuse(refuse),
  .cnt_allocd(cnt_allocd), .cnt_valid(cnt_valid), .cnt_unseen(cnt_unseen), .cnt_free(cnt_free)
);

// File: tb/frame_ring_ptrs_bench.sv
module frame_ring_ptrs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] req_frames = '0;
  logic [8:0] init_base = '0;
  logic [2:0] init_log2 = '0;
  logic       grant_vld, refuse;
  logic [8:0] grant_ofs;
  logic [7:0] grant_frames;
  logic [6:0] cnt_allocd, cnt_valid, cnt_unseen, cnt_free;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frame_ring_ptrs u_frame_ring_ptrs (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .req_frames(req_frames),
    .init_base(init_base), .init_log2(init_log2),
    .grant_vld(grant_vld), .grant_ofs(grant_ofs), .grant_frames(grant_frames), .refuse(refuse),
    .cnt_allocd(cnt_allocd), .cnt_valid(cnt_valid), .cnt_unseen(cnt_unseen), .cnt_free(cnt_free)
  );

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] req;
    logic [3:0] rid;
    logic       vld;
    logic [7:0] cnt;
    logic [8:0] ofs;
    logic       fail;
    logic [6:0] al;
    logic [6:0] va;
    logic [6:0] un;
    logic [6:0] fr;
  } vec_t;

  // ring of 32 frames at base 128
  localparam vec_t TBL [18] = '{
    '{4'd1, 8'd0,  4'd2,  1'b0, 8'd0,  9'd0,   1'b0, 7'd0,  7'd0,  7'd0,  7'd31},
    '{4'd2, 8'd10, 4'd4,  1'b1, 8'd10, 9'd128, 1'b0, 7'd10, 7'd10, 7'd10, 7'd21},
    '{4'd3, 8'd4,  4'd5,  1'b1, 8'd4,  9'd128, 1'b0, 7'd6,  7'd6,  7'd6,  7'd25},
    '{4'd2, 8'd40, 4'd4,  1'b1, 8'd22, 9'd138, 1'b0, 7'd28, 7'd28, 7'd28, 7'd3},
    '{4'd2, 8'd5,  4'd4,  1'b1, 8'd3,  9'd128, 1'b0, 7'd31, 7'd31, 7'd31, 7'd0},
    '{4'd4, 8'd0,  4'd6,  1'b0, 8'd0,  9'd0,   1'b1, 7'd31, 7'd31, 7'd31, 7'd0},
    '{4'd3, 8'd31, 4'd5,  1'b1, 8'd28, 9'd132, 1'b0, 7'd3,  7'd3,  7'd3,  7'd28},
    '{4'd6, 8'd0,  4'd8,  1'b0, 8'd0,  9'd0,   1'b1, 7'd3,  7'd3,  7'd3,  7'd28},
    '{4'd4, 8'd0,  4'd6,  1'b1, 8'd16, 9'd131, 1'b0, 7'd19, 7'd3,  7'd3,  7'd12},
    '{4'd4, 8'd0,  4'd6,  1'b0, 8'd0,  9'd0,   1'b1, 7'd19, 7'd3,  7'd3,  7'd12},
    '{4'd5, 8'd0,  4'd7,  1'b0, 8'd0,  9'd0,   1'b0, 7'd19, 7'd19, 7'd19, 7'd12},
    '{4'd6, 8'd0,  4'd8,  1'b1, 8'd16, 9'd128, 1'b0, 7'd19, 7'd19, 7'd3,  7'd12},
    '{4'd7, 8'd0,  4'd9,  1'b0, 8'd0,  9'd0,   1'b0, 7'd3,  7'd3,  7'd3,  7'd28},
    '{4'd2, 8'd0,  4'd11, 1'b1, 8'd0,  9'd147, 1'b0, 7'd3,  7'd3,  7'd3,  7'd28},
    '{4'd2, 8'd10, 4'd4,  1'b1, 8'd10, 9'd147, 1'b0, 7'd13, 7'd13, 7'd13, 7'd18},
    '{4'd3, 8'd2,  4'd5,  1'b1, 8'd2,  9'd144, 1'b0, 7'd11, 7'd11, 7'd11, 7'd20},
    '{4'd8, 8'd0,  4'd10, 1'b0, 8'd0,  9'd0,   1'b0, 7'd13, 7'd13, 7'd13, 7'd18},
    '{4'd0, 8'd0,  4'd12, 1'b0, 8'd0,  9'd0,   1'b0, 7'd13, 7'd13, 7'd13, 7'd18}
  };

  function automatic string tag(input logic [3:0] id);
    case (id)
      4'd2:    return "R2";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      4'd11:   return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic counts(input string t, input int al, input int va, input int un, input int fr);
    chk(t, "allocd", int'(cnt_allocd), al);
    chk(t, "valid", int'(cnt_valid), va);
    chk(t, "unseen", int'(cnt_unseen), un);
    chk(t, "free", int'(cnt_free), fr);
  endtask

  task automatic do_op(input logic [3:0] o, input logic [7:0] r);
    @(negedge clk);
    op_code = o;
    req_frames = r;
    @(negedge clk);
    op_code = 4'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    counts("R1", 0, 0, 0, 127);
    chk("R1", "grant_vld", int'(grant_vld), 0);
    chk("R1", "refuse", int'(refuse), 0);
    rst_n = 1'b1;
    @(negedge clk);

    init_base = 9'd128;
    init_log2 = 3'd5;
    foreach (TBL[i]) begin
      do_op(TBL[i].op, TBL[i].req);
      chk(tag(TBL[i].rid), "grant_vld", int'(grant_vld), int'(TBL[i].vld));
      chk(tag(TBL[i].rid), "grant_frames", int'(grant_frames), int'(TBL[i].cnt));
      chk(tag(TBL[i].rid), "grant_ofs", int'(grant_ofs), int'(TBL[i].ofs));
      chk(tag(TBL[i].rid), "refuse", int'(refuse), int'(TBL[i].fail));
      counts("R3", int'(TBL[i].al), int'(TBL[i].va), int'(TBL[i].un), int'(TBL[i].fr));
    end

    // R2 re-init to a 16-frame ring at base 0
    init_base = 9'd0;
    init_log2 = 3'd4;
    do_op(4'd1, 8'd0);
    counts("R2", 0, 0, 0, 15);
    // R4 free count limits the grant below the end room
    do_op(4'd2, 8'd20);
    chk("R4", "grant_frames", int'(grant_frames), 15);
    chk("R4", "grant_ofs", int'(grant_ofs), 0);
    // R6 a full 16-frame ring can never hold a multiframe
    do_op(4'd7, 8'd0);
    do_op(4'd4, 8'd0);
    chk("R6", "refuse", int'(refuse), 1);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    counts("R1", 0, 0, 0, 127);
    rst_n = 1'b1;
    do_op(4'd4, 8'd0);
    chk("R6", "grant_vld", int'(grant_vld), 1);
    chk("R6", "grant_ofs", int'(grant_ofs), 0);
    chk("R6", "grant_frames", int'(grant_frames), 16);
    counts("R6", 16, 0, 0, 111);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule